// File: doc/BRIEF.md
# Received Frame Address Filter

This block watches the byte stream of a received wireless LAN frame and decides whether the frame is passed up to the host or dropped. The stream starts with the physical-layer header. The block locates the frame control byte, the receiver address (address 1) and the BSS address (address 3) by their byte position. It then compares them with the station's own MAC address and a stored BSS identifier, and applies a 14-bit category mask. Each mask bit enables one kind of frame: multicast groups, the two broadcast forms, beacons and probe responses, control frames and so on.

Software loads the mask and the two addresses through a small write-only register port. After the last byte of address 3 the block gives exactly one verdict strobe with an accept bit. Bytes after address 3 (sequence control, body, FCS) are not examined.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the verdict strobe is low, the mask is zero and both addresses are zero, so a frame received before any register write is rejected.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register picked by `cfg_sel`. Code 0 is the mask (bits 13:0). Codes 1 and 2 are the own address, low 32 bits and high 16 bits. Codes 3 and 4 are the BSS identifier, low and high. The first address byte on air sits in bits 7:0 of the low register and the sixth byte in bits 15:8 of the high register. A write with any other code changes nothing. The mask written takes effect from the next cycle.
- R3: A byte with `rx_byte_valid` and `rx_sof` high is byte 0 of a frame. Bytes 0-4 are PHY header, byte 5 is frame control, bytes 9-14 are address 1 and bytes 21-26 are address 3, each address sent first byte first. Cycles with `rx_byte_valid` low do not count. `verdict_valid` is high for exactly one cycle: the cycle after byte 26 is taken. A new start-of-frame restarts the count without a verdict for the cut frame, and bytes after byte 26 or before any start-of-frame give no verdict.
- R4: Mask bit 9 accepts a frame whose address 1 equals the own address.
- R5: Mask bit 10 accepts address 1 equal to FF:FF:FF:FF:FF:FF. Mask bit 11 accepts address 1 equal to 00:00:00:00:00:00.
- R6: Mask bit 1 accepts address 1 starting with 01:00:5E or with 33:33.
- R7: Type and subtype are frame-control bits 3:2 and 7:4. Mask bit 4 accepts every beacon (type 0, subtype 8) and every probe response (type 0, subtype 5). Mask bit 12 accepts a beacon whose address 3 equals the BSS identifier.
- R8: Mask bit 5 accepts any control frame (type 1). Mask bit 7 accepts a PS-Poll (type 1, subtype 10). Mask bit 8 accepts a probe request (type 0, subtype 4).
- R9: Mask bit 6 accepts a frame whose address 3 differs from the BSS identifier.
- R10: Mask bit 13 accepts every frame.
- R11: Mask bits 0, 2 and 3 are stored but never cause acceptance.
- R12: The frame is accepted when any enabled category matches. `verdict_accept` is low whenever `verdict_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| rx_byte_valid | input | 1 | Received byte qualifier |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Received byte |
| verdict_valid | output | 1 | One-cycle decision strobe |
| verdict_accept | output | 1 | Frame accepted (meaningful with the strobe) |

## Verification
The assertions assume that at least 27 counted bytes separate two starts of frame, so that two verdict strobes can never be adjacent. They also assume that a start-of-frame is only ever given together with a valid byte. The bench sends every frame as a complete 29-byte run, including aborted runs that are restarted with a fresh start-of-frame. Register writes happen only between frames, so the mask and addresses are stable while a header passes.

// File: rtl/rxf_pkg.sv
// Shared constants for the received-frame address filter: mask bit
// positions, register select codes and header field sizes.
package rxf_pkg;
    localparam int FLAG_W     = 14;
    localparam int ADDR_BYTES = 6;
    localparam int MAC_W      = 8 * ADDR_BYTES;

    // category mask bit positions
    localparam int FLG_MCAST     = 1;
    localparam int FLG_BCN_ANY   = 4;
    localparam int FLG_CTRL      = 5;
    localparam int FLG_OTHER_BSS = 6;
    localparam int FLG_PSPOLL    = 7;
    localparam int FLG_PROBE_REQ = 8;
    localparam int FLG_UCAST     = 9;
    localparam int FLG_BC_ONES   = 10;
    localparam int FLG_BC_ZEROS  = 11;
    localparam int FLG_OWN_BCN   = 12;
    localparam int FLG_MONITOR   = 13;

    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_OWN_LO = 3'd1,
        SEL_OWN_HI = 3'd2,
        SEL_BSS_LO = 3'd3,
        SEL_BSS_HI = 3'd4
    } cfg_sel_e;
endpackage

// File: rtl/rxf_cfg_regs.sv
// Configuration store: category mask, own address and BSS identifier.
// Assumes DATA_W < MAC_W; the high register holds the remaining bits.
module rxf_cfg_regs #(
    parameter int FLAG_W = rxf_pkg::FLAG_W,
    parameter int MAC_W  = rxf_pkg::MAC_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags,
    output logic [MAC_W-1:0]  own_mac,
    output logic [MAC_W-1:0]  bssid
);
    import rxf_pkg::*;
    localparam int HI_W = MAC_W - DATA_W;

    // register writes decoded by select code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            own_mac <= '0;
            bssid   <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_MASK:   flags                  <= wdata[FLAG_W-1:0];
                SEL_OWN_LO: own_mac[DATA_W-1:0]    <= wdata;
                SEL_OWN_HI: own_mac[MAC_W-1:DATA_W] <= wdata[HI_W-1:0];
                SEL_BSS_LO: bssid[DATA_W-1:0]      <= wdata;
                SEL_BSS_HI: bssid[MAC_W-1:DATA_W]  <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxf_hdr_capture.sv
// Counts bytes from start-of-frame and captures the frame-control type
// bits and addresses 1 and 3. Pulses hdr_done the cycle after the last
// byte of address 3. Assumes rx_sof only comes with a valid byte.
module rxf_hdr_capture #(
    parameter int PHY_BYTES  = 5,
    parameter int ADDR_BYTES = rxf_pkg::ADDR_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic                    sof,
    input  logic [7:0]              din,
    output logic [5:0]              fc_ts,
    output logic [8*ADDR_BYTES-1:0] addr1,
    output logic [8*ADDR_BYTES-1:0] addr3,
    output logic                    hdr_done
);
    localparam int FC_IDX   = PHY_BYTES;
    localparam int A1_IDX   = FC_IDX + 4;
    localparam int A3_IDX   = A1_IDX + 2 * ADDR_BYTES;
    localparam int LAST_IDX = A3_IDX + ADDR_BYTES - 1;
    localparam int CW       = $clog2(LAST_IDX + 1);

    logic [CW-1:0] idx;
    logic          armed;
    logic          take;

    assign take = byte_valid && armed && !sof;

    // byte index tracking and end-of-header pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            armed    <= 1'b0;
            hdr_done <= 1'b0;
        end else begin
            hdr_done <= take && (idx == CW'(LAST_IDX));
            if (byte_valid && sof) begin
                idx   <= CW'(1);
                armed <= 1'b1;
            end else if (take) begin
                idx <= idx + CW'(1);
                if (idx == CW'(LAST_IDX)) armed <= 1'b0;
            end
        end
    end

    // frame-control type and subtype capture
    always_ff @(posedge clk) begin
        if (!rst_n) fc_ts <= '0;
        else if (take && idx == CW'(FC_IDX)) fc_ts <= din[7:2];
    end

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
        localparam logic [CW-1:0] I1 = CW'(A1_IDX + k);
        localparam logic [CW-1:0] I3 = CW'(A3_IDX + k);
        // one byte lane of each address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr1[8*k +: 8] <= '0;
                addr3[8*k +: 8] <= '0;
            end else if (take) begin
                if (idx == I1) addr1[8*k +: 8] <= din;
                if (idx == I3) addr3[8*k +: 8] <= din;
            end
        end
    end
endmodule

// File: rtl/rxf_decide.sv
// Combinational verdict: builds one hit bit per mask category and
// accepts when any enabled category hits. Mask bits 0, 2 and 3 never hit.
module rxf_decide #(
    parameter int FLAG_W = rxf_pkg::FLAG_W,
    parameter int MAC_W  = rxf_pkg::MAC_W
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [MAC_W-1:0]  own_mac,
    input  logic [MAC_W-1:0]  bssid,
    input  logic [5:0]        fc_ts,
    input  logic [MAC_W-1:0]  addr1,
    input  logic [MAC_W-1:0]  addr3,
    input  logic              hdr_done,
    output logic              verdict_valid,
    output logic              verdict_accept
);
    import rxf_pkg::*;
    logic [1:0]        ftype;
    logic [3:0]        fsub;
    logic [FLAG_W-1:0] hit;
    logic              is_beacon, is_presp, is_preq, is_ctrl, is_pspoll;
    logic              bss_match, mcast;

    // classify the frame and its addresses
    always_comb begin
        ftype     = fc_ts[1:0];
        fsub      = fc_ts[5:2];
        is_ctrl   = (ftype == 2'b01);
        is_pspoll = is_ctrl && (fsub == 4'hA);
        is_beacon = (ftype == 2'b00) && (fsub == 4'h8);
        is_presp  = (ftype == 2'b00) && (fsub == 4'h5);
        is_preq   = (ftype == 2'b00) && (fsub == 4'h4);
        bss_match = (addr3 == bssid);
        mcast     = (addr1[23:0] == 24'h5E_00_01) || (addr1[15:0] == 16'h33_33);
    end

    // per-category hit vector
    always_comb begin
        hit                = '0;
        hit[FLG_MCAST]     = mcast;
        hit[FLG_BCN_ANY]   = is_beacon || is_presp;
        hit[FLG_CTRL]      = is_ctrl;
        hit[FLG_OTHER_BSS] = !bss_match;
        hit[FLG_PSPOLL]    = is_pspoll;
        hit[FLG_PROBE_REQ] = is_preq;
        hit[FLG_UCAST]     = (addr1 == own_mac);
        hit[FLG_BC_ONES]   = &addr1;
        hit[FLG_BC_ZEROS]  = ~|addr1;
        hit[FLG_OWN_BCN]   = is_beacon && bss_match;
        hit[FLG_MONITOR]   = 1'b1;
    end

    assign verdict_valid  = hdr_done;
    assign verdict_accept = hdr_done && |(flags & hit);
endmodule

// File: rtl/rx_addr_filter.sv
// Received frame address filter top: register store, header capture
// and verdict logic. Gives one verdict per frame after address 3.
module rx_addr_filter #(
    parameter int PHY_BYTES = 5,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rx_byte_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              verdict_valid,
    output logic              verdict_accept
);
    import rxf_pkg::*;
    logic [FLAG_W-1:0] filter_flags;
    logic [MAC_W-1:0]  own_mac, bssid, addr1, addr3;
    logic [5:0]        fc_ts;
    logic              hdr_done;

    rxf_cfg_regs #(.FLAG_W(FLAG_W), .MAC_W(MAC_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .flags(filter_flags), .own_mac(own_mac), .bssid(bssid)
    );

    rxf_hdr_capture #(.PHY_BYTES(PHY_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .byte_valid(rx_byte_valid), .sof(rx_sof),
        .din(rx_byte), .fc_ts(fc_ts), .addr1(addr1), .addr3(addr3),
        .hdr_done(hdr_done)
    );

    rxf_decide #(.FLAG_W(FLAG_W), .MAC_W(MAC_W)) u_dec (
        .flags(filter_flags), .own_mac(own_mac), .bssid(bssid), .fc_ts(fc_ts),
        .addr1(addr1), .addr3(addr3), .hdr_done(hdr_done),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );
endmodule

// File: rtl/rxf_chk.sv
// Property checker for rx_addr_filter, attached by bind.
module rxf_chk #(
    parameter int FLAG_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic [31:0]       cfg_wdata,
    input logic              rx_byte_valid,
    input logic              rx_sof,
    input logic              verdict_valid,
    input logic              verdict_accept,
    input logic [FLAG_W-1:0] filter_flags
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid); // R3
    AST_AFTER_HEADER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(rx_byte_valid && !rx_sof)); // R3
    AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> !verdict_accept); // R12
    AST_MONITOR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && filter_flags[13]) |-> verdict_accept); // R10
    AST_NOTHING_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && (filter_flags & 14'h3FF2) == '0) |-> !verdict_accept); // R11
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd0) |=> filter_flags == $past(cfg_wdata[FLAG_W-1:0])); // R2
endmodule

bind rx_addr_filter rxf_chk #(.FLAG_W(14)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_byte_valid(rx_byte_valid), .rx_sof(rx_sof),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
    .filter_flags(filter_flags)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_byte_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        verdict_valid, verdict_accept;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [13:0] cur_flags = '0;
    logic [47:0] cur_own = '0;
    logic [47:0] cur_bss = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_byte_valid(rx_byte_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .verdict_valid(verdict_valid),
        .verdict_accept(verdict_accept)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference decision written from the requirements
    function automatic bit ref_accept(logic [13:0] f, logic [7:0] fc,
                                      logic [47:0] a1, logic [47:0] a3,
                                      logic [47:0] own, logic [47:0] bss);
        bit ctl  = fc[3:2] == 2'd1;
        bit mgmt = fc[3:2] == 2'd0;
        bit bcn  = mgmt && fc[7:4] == 4'd8;
        bit r = 0;
        if (f[13]) r = 1;                                            // R10
        if (f[9]  && a1 == own) r = 1;                               // R4
        if (f[10] && a1 == 48'hFFFF_FFFF_FFFF) r = 1;                // R5
        if (f[11] && a1 == 48'h0) r = 1;                             // R5
        if (f[1] && ((a1[7:0] == 8'h01 && a1[15:8] == 8'h00 && a1[23:16] == 8'h5E) ||
                     (a1[7:0] == 8'h33 && a1[15:8] == 8'h33))) r = 1; // R6
        if (f[4]  && (bcn || (mgmt && fc[7:4] == 4'd5))) r = 1;     // R7
        if (f[12] && bcn && a3 == bss) r = 1;                        // R7
        if (f[5]  && ctl) r = 1;                                     // R8
        if (f[7]  && ctl && fc[7:4] == 4'hA) r = 1;                  // R8
        if (f[8]  && mgmt && fc[7:4] == 4'd4) r = 1;                 // R8
        if (f[6]  && a3 != bss) r = 1;                               // R9
        return r;
    endfunction

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 3'd0) cur_flags = d[13:0];
        if (sel == 3'd1) cur_own[31:0] = d;
        if (sel == 3'd2) cur_own[47:32] = d[15:0];
        if (sel == 3'd3) cur_bss[31:0] = d;
        if (sel == 3'd4) cur_bss[47:32] = d[15:0];
    endtask

    task automatic set_addrs(logic [47:0] own, logic [47:0] bss);
        wr(3'd1, own[31:0]); wr(3'd2, {16'h0, own[47:32]});
        wr(3'd3, bss[31:0]); wr(3'd4, {16'h0, bss[47:32]});
    endtask

    // sends one 29-byte frame; optional idle gaps and a cut-off lead run
    task automatic send_frame(string req, logic [7:0] fc, logic [47:0] a1,
                              logic [47:0] a3, bit gaps, int cut);
        logic [7:0] b[29];
        bit vv = 0, va = 0;
        int spurious = 0;
        bit exp = ref_accept(cur_flags, fc, a1, a3, cur_own, cur_bss);
        for (int i = 0; i < 29; i++) b[i] = 8'($urandom);
        b[5] = fc;
        for (int k = 0; k < 6; k++) begin
            b[9 + k]  = a1[8*k +: 8];
            b[21 + k] = a3[8*k +: 8];
        end
        for (int i = 0; i < cut; i++) begin
            @(negedge clk);
            rx_byte_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'($urandom);
            @(posedge clk); #1;
            if (verdict_valid) spurious++;
        end
        for (int i = 0; i < 29; i++) begin
            @(negedge clk);
            rx_byte_valid = 1'b1; rx_sof = (i == 0); rx_byte = b[i];
            @(posedge clk); #1;
            if (i == 26) begin vv = verdict_valid; va = verdict_accept; end
            else if (verdict_valid) spurious++;
            if (gaps && ($urandom % 3 == 0) && i != 26) begin
                @(negedge clk);
                rx_byte_valid = 1'b0; rx_sof = 1'b0;
                @(posedge clk); #1;
                if (verdict_valid) spurious++;
            end
        end
        @(negedge clk);
        rx_byte_valid = 1'b0; rx_sof = 1'b0;
        @(posedge clk); #1;
        if (verdict_valid || verdict_accept) spurious++;
        check({req, " verdict"}, {30'd0, vv, va}, {30'd0, 1'b1, exp});
        check("R3 single strobe", spurious, 0);
    endtask

    localparam logic [47:0] OWN = 48'h55_44_33_22_11_02;  // 02:11:22:33:44:55
    localparam logic [47:0] BSS = 48'h0F_0E_0D_0C_0B_0A;
    localparam logic [47:0] OTHER = 48'h99_88_77_66_55_44;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset strobe", {31'd0, verdict_valid}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: no config yet
        send_frame("R1", 8'h80, 48'hFFFF_FFFF_FFFF, 48'h0, 0, 0);

        set_addrs(OWN, BSS);
        wr(3'd0, 32'h0000_0200);                                   // bit9
        send_frame("R4", 8'h08, OWN, BSS, 0, 0);
        send_frame("R2 byte order", 8'h08, {8'h56, OWN[39:0]}, BSS, 0, 0);
        wr(3'd6, 32'hFFFF_FFFF);                                   // unused code
        send_frame("R2 unused select", 8'h08, OWN, BSS, 0, 0);

        wr(3'd0, 32'h0000_0400);                                   // bit10
        send_frame("R5 ones", 8'h08, 48'hFFFF_FFFF_FFFF, BSS, 0, 0);
        send_frame("R5 zeros off", 8'h08, 48'h0, BSS, 0, 0);
        wr(3'd0, 32'h0000_0800);                                   // bit11
        send_frame("R5 zeros", 8'h08, 48'h0, BSS, 0, 0);

        wr(3'd0, 32'h0000_0002);                                   // bit1
        send_frame("R6 v4", 8'h08, 48'h11_22_33_5E_00_01, BSS, 0, 0);
        send_frame("R6 v6", 8'h08, 48'h11_22_33_44_33_33, BSS, 0, 0);
        send_frame("R6 near", 8'h08, 48'h11_22_33_5F_00_01, BSS, 0, 0);

        wr(3'd0, 32'h0000_1000);                                   // bit12
        send_frame("R7 own beacon", 8'h80, OTHER, BSS, 0, 0);
        send_frame("R7 foreign beacon", 8'h80, OTHER, OTHER, 0, 0);
        wr(3'd0, 32'h0000_0010);                                   // bit4
        send_frame("R7 probe resp", 8'h50, OTHER, OTHER, 0, 0);

        wr(3'd0, 32'h0000_0020);                                   // bit5
        send_frame("R8 control", 8'hD4, OTHER, BSS, 0, 0);
        wr(3'd0, 32'h0000_0080);                                   // bit7
        send_frame("R8 pspoll", 8'hA4, OTHER, BSS, 0, 0);
        send_frame("R8 ack not pspoll", 8'hD4, OTHER, BSS, 0, 0);
        wr(3'd0, 32'h0000_0100);                                   // bit8
        send_frame("R8 probe req", 8'h40, OTHER, BSS, 0, 0);

        wr(3'd0, 32'h0000_0040);                                   // bit6
        send_frame("R9 other bss", 8'h08, OTHER, OTHER, 0, 0);
        send_frame("R9 same bss", 8'h08, OTHER, BSS, 0, 0);

        wr(3'd0, 32'h0000_2000);                                   // bit13
        send_frame("R10", 8'h08, OTHER, OTHER, 0, 0);

        wr(3'd0, 32'h0000_000D);                                   // bits 0,2,3
        send_frame("R11", 8'h80, 48'hFFFF_FFFF_FFFF, BSS, 0, 0);

        wr(3'd0, 32'h0000_0600);                                   // bits 9,10
        send_frame("R12 or", 8'h08, 48'hFFFF_FFFF_FFFF, BSS, 0, 0);
        send_frame("R3 gaps", 8'h08, OWN, BSS, 1, 0);
        send_frame("R3 restart", 8'h08, OWN, BSS, 0, 15);

        for (int n = 0; n < 80; n++) begin
            logic [7:0]  fcs[7] = '{8'h80, 8'h50, 8'h40, 8'hA4, 8'hD4, 8'h08, 8'h00};
            logic [47:0] a1, a3;
            logic [7:0]  fc;
            int sel_a1 = $urandom % 5;
            if (n % 8 == 0) set_addrs({$urandom, $urandom} & 48'hFEFF_FFFF_FFFF,
                                      {$urandom, $urandom});
            wr(3'd0, $urandom & $urandom & 32'h0000_1FFF | ((n % 11 == 0) ? 32'h2000 : 0));
            fc = fcs[$urandom % 7];
            if (fc == 8'h00) fc = 8'($urandom);
            case (sel_a1)
                0: a1 = cur_own;
                1: a1 = 48'hFFFF_FFFF_FFFF;
                2: a1 = 48'h0;
                3: a1 = ($urandom % 2) ? {24'($urandom), 24'h5E_00_01}
                                       : {32'($urandom), 16'h33_33};
                default: a1 = {16'($urandom), $urandom};
            endcase
            a3 = ($urandom % 2) ? cur_bss : {16'($urandom), $urandom};
            send_frame("R12 random", fc, a1, a3, ($urandom % 4 == 0), (n % 9 == 0) ? 7 : 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule